// File: doc/BRIEF.md
# Outstanding Read Completion Tracker

This block keeps the bookkeeping for memory read requests that have been sent toward a PCIe link and are still waiting for their completions. When a requester presents a read, the block hands out the lowest free tag and stores a small requester context word in the matching table entry. It also starts an age counter for that entry. Returning completion headers carry a tag, a three-bit status, a poison flag and a last-part flag. The block looks each one up in the table. It reports a matched completion together with the stored context, and it retires the entry once the read has finished.

The block raises single-cycle error pulses for four separate conditions, each with the tag involved. These are a completion for a tag that is not pending, an unsupported-request status, a poisoned completion, and an entry that has waited too long. The age counters advance on a prescaled tick. A build-time selector chooses between a short and a long timeout limit, so a bench can cut simulated time by shrinking the tick period and the limits. Packet formatting, payload storage and reordering belong to other blocks.

Top module: `rd_cpl_tracker`

## Requirements
- R1: The table holds DEPTH (default 8) entries. `req_ready` is low exactly when every entry is pending. A request presented while `req_ready` is low allocates nothing.
- R2: While `req_ready` is high, `req_tag` shows the lowest-numbered free entry. A request with `req_valid` high claims that entry at the next clock edge.
- R3: A completion whose tag names a pending entry gives a `cpl_done` pulse one cycle later. In that cycle `rsp_tag` carries the tag and `rsp_ctx` carries the context stored at allocation.
- R4: A matched completion with status 3'b000 retires its entry only when `cpl_last` is 1. With `cpl_last` at 0 the entry stays pending, so a later part of the same read still matches.
- R5: A matched completion with status 3'b001 (unsupported request) gives an `err_ur` pulse with its tag in `rsp_tag`. Any matched completion with a non-zero status retires the entry whatever `cpl_last` is.
- R6: A matched completion with `cpl_poison` set gives an `err_poison` pulse with its tag in `rsp_tag`. Whether the entry retires still follows R4 and R5.
- R7: A completion whose tag names no pending entry gives an `err_unexp` pulse with its tag in `rsp_tag`. It gives no `cpl_done` pulse and leaves the table unchanged.
- R8: An entry's age starts at 0 when it is allocated. The age rises by one on each prescaler tick, and a tick occurs once every TICK_DIV cycles counted from reset. Once the age equals the limit, the entry is retired and `err_timeout` pulses one cycle later with `to_tag`. When several entries have expired, the lowest-numbered one goes first, one per cycle. An entry hit by a completion in a given cycle is not timed out in that cycle.
- R9: With LONG_SEL = 0 the limit is TO_SHORT ticks. With LONG_SEL = 1 it is TO_LONG ticks.
- R10: After a synchronous active-low reset, the table is empty, `req_ready` is 1, `req_tag` is 0 and every pulse output is 0.
- R11: Each of `cpl_done`, `err_unexp`, `err_ur`, `err_poison` and `err_timeout` is a single-cycle pulse per event. `cpl_done` and `err_unexp` never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A read request is being issued |
| req_ctx | input | CTX_W | Requester context to store with the request |
| req_ready | output | 1 | A free entry exists |
| req_tag | output | TAG_W | Tag the next request will receive |
| cpl_valid | input | 1 | A completion header is present |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| cpl_status | input | 3 | Completion status code |
| cpl_poison | input | 1 | Completion is poisoned |
| cpl_last | input | 1 | Final part of a split completion |
| cpl_done | output | 1 | Pulse: completion matched a pending entry |
| rsp_tag | output | TAG_W | Tag of the completion reported this cycle |
| rsp_ctx | output | CTX_W | Stored context of the matched entry |
| err_unexp | output | 1 | Pulse: completion for a tag not pending |
| err_ur | output | 1 | Pulse: unsupported-request status |
| err_poison | output | 1 | Pulse: poisoned completion |
| err_timeout | output | 1 | Pulse: entry expired and was retired |
| to_tag | output | TAG_W | Tag of the expired entry |

## Verification
The assertions expect `cpl_tag` to lie within the table and `cpl_status` to be a defined three-bit value. They also expect `req_valid` and the completion inputs to be 0 while reset is held, because several properties look one cycle back at them. The stimulus meets these conditions as follows. It keeps every input at 0 during reset, draws tags only from 0 to DEPTH-1, and changes inputs only on the falling clock edge. It mixes tags of pending and free entries so that matched completions and unexpected completions both occur often. It also leaves idle stretches long enough for timeouts to fire, including cases where several entries expire at once.

// File: rtl/rct_pkg.sv
// Package rct_pkg: shared completion status codes for the read tracker.
// Assumes the three-bit status encoding of the link's completion header.
package rct_pkg;
    localparam logic [2:0] ST_SUCCESS = 3'b000;
    localparam logic [2:0] ST_UNSUPP  = 3'b001;
endpackage

// File: rtl/rct_tick.sv
// Module rct_tick: free-running prescaler that gives a one-cycle tick every
// DIV cycles, counted from reset. Assumes DIV >= 1.
module rct_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Count cycles and wrap when the tick fires.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rct_pick.sv
// Module rct_pick: finds the lowest set bit of a request vector and returns
// its index. Assumes N <= 2**IW.
module rct_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rct_entry.sv
// Module rct_entry: one table slot that holds a pending flag, the stored
// requester context and a saturating age in ticks. Assumes alloc and retire
// are never both high (alloc only targets a free slot, retire only a busy one).
module rct_entry #(
    parameter int CTX_W = 8,
    parameter int AGE_W = 6,
    parameter int LIMIT = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [CTX_W-1:0] ctx_in,
    input  logic             retire,
    input  logic             tick,
    output logic             busy,
    output logic [CTX_W-1:0] ctx,
    output logic             expired
);
    logic [AGE_W-1:0] age;

    assign expired = busy && (age == AGE_W'(LIMIT));

    // Claim, release or age the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ctx  <= '0;
            age  <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            ctx  <= ctx_in;
            age  <= '0;
        end else if (retire) begin
            busy <= 1'b0;
        end else if (busy && tick && !expired) begin
            age  <= age + 1'b1;
        end
    end
endmodule

// File: rtl/rd_cpl_tracker.sv
// Module rd_cpl_tracker: tracks outstanding non-posted reads. It allocates
// tags, matches completion headers, retires finished entries, and pulses
// one of four error classes. Assumes DEPTH is a power of two, so every
// cpl_tag value names a table slot. All reported outputs are registered.
module rd_cpl_tracker
    import rct_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int CTX_W    = 8,
    parameter int TICK_DIV = 125,
    parameter int TO_SHORT = 50,
    parameter int TO_LONG  = 50000,
    parameter bit LONG_SEL = 1'b0,
    localparam int TAG_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CTX_W-1:0] req_ctx,
    output logic             req_ready,
    output logic [TAG_W-1:0] req_tag,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [2:0]       cpl_status,
    input  logic             cpl_poison,
    input  logic             cpl_last,
    output logic             cpl_done,
    output logic [TAG_W-1:0] rsp_tag,
    output logic [CTX_W-1:0] rsp_ctx,
    output logic             err_unexp,
    output logic             err_ur,
    output logic             err_poison,
    output logic             err_timeout,
    output logic [TAG_W-1:0] to_tag
);
    localparam int LIMIT = LONG_SEL ? TO_LONG : TO_SHORT;
    localparam int MAXL  = (TO_LONG > TO_SHORT) ? TO_LONG : TO_SHORT;
    localparam int AGE_W = $clog2(MAXL + 1);

    logic             tick;
    logic [DEPTH-1:0] ent_valid, ent_exp, hit, alloc_v, retire_v, to_cand;
    logic [CTX_W-1:0] ent_ctx [DEPTH];
    logic             free_found, to_found, matched, finish;
    logic [TAG_W-1:0] free_idx, to_idx;

    rct_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    rct_pick #(.N(DEPTH), .IW(TAG_W)) u_free (
        .req(~ent_valid), .found(free_found), .idx(free_idx));

    rct_pick #(.N(DEPTH), .IW(TAG_W)) u_expire (
        .req(to_cand), .found(to_found), .idx(to_idx));

    assign req_ready = free_found;
    assign req_tag   = free_idx;
    assign matched   = cpl_valid && ent_valid[cpl_tag];
    assign finish    = cpl_last || (cpl_status != ST_SUCCESS);

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            assign hit[g]      = cpl_valid && (cpl_tag == TAG_W'(g)) && ent_valid[g];
            assign to_cand[g]  = ent_exp[g] && !hit[g];
            assign alloc_v[g]  = req_valid && free_found && (free_idx == TAG_W'(g));
            assign retire_v[g] = (hit[g] && finish) ||
                                 (to_found && (to_idx == TAG_W'(g)));
            rct_entry #(.CTX_W(CTX_W), .AGE_W(AGE_W), .LIMIT(LIMIT)) u_ent (
                .clk(clk), .rst_n(rst_n), .alloc(alloc_v[g]), .ctx_in(req_ctx),
                .retire(retire_v[g]), .tick(tick), .busy(ent_valid[g]),
                .ctx(ent_ctx[g]), .expired(ent_exp[g]));
        end
    endgenerate

    // Register the completion verdict and the timeout report as pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_done    <= 1'b0;
            err_unexp   <= 1'b0;
            err_ur      <= 1'b0;
            err_poison  <= 1'b0;
            err_timeout <= 1'b0;
            rsp_tag     <= '0;
            rsp_ctx     <= '0;
            to_tag      <= '0;
        end else begin
            cpl_done    <= matched;
            err_unexp   <= cpl_valid && !matched;
            err_ur      <= matched && (cpl_status == ST_UNSUPP);
            err_poison  <= matched && cpl_poison;
            err_timeout <= to_found;
            rsp_tag     <= cpl_tag;
            rsp_ctx     <= ent_ctx[cpl_tag];
            to_tag      <= to_idx;
        end
    end
endmodule

// File: rtl/rct_checker.sv
// Module rct_checker: temporal properties of rd_cpl_tracker, attached by bind.
// Assumes inputs are held at 0 during reset.
module rct_checker #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             cpl_valid,
    input logic [TAG_W-1:0] cpl_tag,
    input logic [2:0]       cpl_status,
    input logic             cpl_poison,
    input logic             cpl_last,
    input logic             cpl_done,
    input logic [TAG_W-1:0] rsp_tag,
    input logic             err_unexp,
    input logic             err_ur,
    input logic             err_poison,
    input logic             err_timeout,
    input logic [TAG_W-1:0] to_tag,
    input logic [DEPTH-1:0] valid_vec
);
    a_r1_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (&valid_vec));

    a_r4_partial_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_done && !$past(cpl_last) && ($past(cpl_status) == 3'b000))
        |-> valid_vec[rsp_tag]);

    a_r5_ur_status: assert property (@(posedge clk) disable iff (!rst_n)
        err_ur |-> (($past(cpl_status) == 3'b001) && cpl_done));

    a_r6_poison_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_poison |-> ($past(cpl_poison) && cpl_done));

    a_r7_unexp_tag: assert property (@(posedge clk) disable iff (!rst_n)
        err_unexp |-> ($past(cpl_valid) && !$past(valid_vec[cpl_tag])));

    a_r8_timeout_frees: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (!valid_vec[to_tag] &&
                         ((($past(valid_vec) >> to_tag) & 1) != 0)));

    a_r11_done_xor_unexp: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpl_done && err_unexp));
endmodule

bind rd_cpl_tracker rct_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cpl_valid(cpl_valid),
    .cpl_tag(cpl_tag), .cpl_status(cpl_status), .cpl_poison(cpl_poison),
    .cpl_last(cpl_last), .cpl_done(cpl_done), .rsp_tag(rsp_tag),
    .err_unexp(err_unexp), .err_ur(err_ur), .err_poison(err_poison),
    .err_timeout(err_timeout), .to_tag(to_tag), .valid_vec(ent_valid));

// File: tb/sim_rd_cpl_tracker.sv
// Bench for rd_cpl_tracker: a behavioural reference model, compared every cycle.
module sim_rd_cpl_tracker;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int CTX_W  = 8;
    localparam int DIV    = 3;
    localparam int SHORT  = 5;
    localparam int LONG   = 12;
    localparam int TW     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [CTX_W-1:0] req_ctx = '0;
    logic cpl_valid = 1'b0;
    logic [TW-1:0] cpl_tag = '0;
    logic [2:0] cpl_status = '0;
    logic cpl_poison = 1'b0;
    logic cpl_last = 1'b0;

    logic req_ready, cpl_done, err_unexp, err_ur, err_poison, err_timeout;
    logic [TW-1:0] req_tag, rsp_tag, to_tag;
    logic [CTX_W-1:0] rsp_ctx;
    logic l_ready, l_done, l_unexp, l_ur, l_pois, l_to;
    logic [TW-1:0] l_rtag, l_rsptag, l_totag;
    logic [CTX_W-1:0] l_ctx;

    always #(PERIOD/2) clk = ~clk;

    rd_cpl_tracker #(.DEPTH(DEPTH), .CTX_W(CTX_W), .TICK_DIV(DIV),
        .TO_SHORT(SHORT), .TO_LONG(LONG), .LONG_SEL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
        .req_ready(req_ready), .req_tag(req_tag), .cpl_valid(cpl_valid),
        .cpl_tag(cpl_tag), .cpl_status(cpl_status), .cpl_poison(cpl_poison),
        .cpl_last(cpl_last), .cpl_done(cpl_done), .rsp_tag(rsp_tag),
        .rsp_ctx(rsp_ctx), .err_unexp(err_unexp), .err_ur(err_ur),
        .err_poison(err_poison), .err_timeout(err_timeout), .to_tag(to_tag));

    rd_cpl_tracker #(.DEPTH(DEPTH), .CTX_W(CTX_W), .TICK_DIV(DIV),
        .TO_SHORT(SHORT), .TO_LONG(LONG), .LONG_SEL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
        .req_ready(l_ready), .req_tag(l_rtag), .cpl_valid(cpl_valid),
        .cpl_tag(cpl_tag), .cpl_status(cpl_status), .cpl_poison(cpl_poison),
        .cpl_last(cpl_last), .cpl_done(l_done), .rsp_tag(l_rsptag),
        .rsp_ctx(l_ctx), .err_unexp(l_unexp), .err_ur(l_ur),
        .err_poison(l_pois), .err_timeout(l_to), .to_tag(l_totag));

    int nchk = 0, nbad = 0, cyc = 0, pc = 0;
    bit finished = 1'b0;
    bit mv [DEPTH];
    int mage [DEPTH];
    int mctx [DEPTH];
    int seen0 = -1, seen1 = -1;

    task automatic chk(string rq, int act, int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // One clock: drive inputs, check combinational outputs, advance the model, check pulses.
    task automatic step(bit rv, int rc, bit cv, int ct, int cs, bit cp, bit cl);
        int  ftag, totag;
        bit  fready, tick, match, e_done, e_unexp, e_ur, e_pois, e_to;
        int  e_ctx;
        @(negedge clk);
        req_valid = rv; req_ctx = CTX_W'(rc); cpl_valid = cv; cpl_tag = TW'(ct);
        cpl_status = 3'(cs); cpl_poison = cp; cpl_last = cl;
        #1;
        fready = 1'b0; ftag = 0;
        for (int i = DEPTH - 1; i >= 0; i--) if (!mv[i]) begin fready = 1'b1; ftag = i; end
        chk("R1 req_ready", int'(req_ready), int'(fready));
        if (fready) chk("R2 req_tag", int'(req_tag), ftag);
        tick    = (pc == DIV - 1);
        match   = cv && mv[ct];
        e_done  = match;
        e_ctx   = mctx[ct];
        e_unexp = cv && !match;
        e_ur    = match && (cs == 1);
        e_pois  = match && cp;
        e_to = 1'b0; totag = 0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (mv[i] && mage[i] == SHORT && !(match && i == ct)) begin e_to = 1'b1; totag = i; end
        if (match && (cl || cs != 0)) mv[ct] = 1'b0;
        if (e_to) mv[totag] = 1'b0;
        for (int i = 0; i < DEPTH; i++) if (mv[i] && tick && mage[i] < SHORT) mage[i]++;
        if (rv && fready) begin mv[ftag] = 1'b1; mage[ftag] = 0; mctx[ftag] = rc; end
        pc = (pc + 1) % DIV;
        @(posedge clk); #1;
        cyc++;
        chk("R3 cpl_done", int'(cpl_done), int'(e_done));
        if (e_done) begin
            chk("R3 rsp_tag", int'(rsp_tag), ct);
            chk("R3 rsp_ctx", int'(rsp_ctx), e_ctx);
        end
        chk("R7 err_unexp", int'(err_unexp), int'(e_unexp));
        if (e_unexp) chk("R7 rsp_tag", int'(rsp_tag), ct);
        chk("R5 err_ur", int'(err_ur), int'(e_ur));
        chk("R6 err_poison", int'(err_poison), int'(e_pois));
        if (e_ur || e_pois) chk("R5 R6 rsp_tag", int'(rsp_tag), ct);
        chk("R8 err_timeout", int'(err_timeout), int'(e_to));
        if (e_to) chk("R8 to_tag", int'(to_tag), totag);
        chk("R11 done/unexp exclusive", int'(cpl_done && err_unexp), 0);
        if (err_timeout && seen0 < 0) seen0 = cyc;
        if (l_to && seen1 < 0) seen1 = cyc;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        if (!finished) begin
            nbad++; nchk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin : stim
        int acyc;
        for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; mage[i] = 0; mctx[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state at the ports
        chk("R10 req_ready", int'(req_ready), 1);
        chk("R10 req_tag", int'(req_tag), 0);
        chk("R10 pulses", int'({cpl_done, err_unexp, err_ur, err_poison, err_timeout}), 0);
        rst_n = 1'b1;
        pc = 0;

        // R9: one request, timeout latency for the short and long limits
        step(1, 8'h5A, 0, 0, 0, 0, 0);
        acyc = cyc;
        idle((LONG + 2) * DIV);
        chk("R9 short timeout seen", int'(seen0 >= 0), 1);
        chk("R9 short window", int'(seen0 - acyc >= (SHORT - 1) * DIV &&
                                    seen0 - acyc <= SHORT * DIV + 2), 1);
        chk("R9 long timeout seen", int'(seen1 >= 0), 1);
        chk("R9 long window", int'(seen1 - acyc >= (LONG - 1) * DIV &&
                                   seen1 - acyc <= LONG * DIV + 2), 1);

        // R1 R2: fill the table, then a ninth request is held off
        for (int i = 0; i < DEPTH; i++) step(1, 16 + i, 0, 0, 0, 0, 0);
        step(1, 99, 0, 0, 0, 0, 0);
        // R4: split completion on tag 3, then its last part
        step(0, 0, 1, 3, 0, 0, 0);
        step(0, 0, 1, 3, 0, 0, 1);
        // R5: unsupported request on tag 5 without last retires it
        step(0, 0, 1, 5, 1, 0, 0);
        // R6: poisoned completion on tag 1
        step(0, 0, 1, 1, 0, 1, 1);
        // R7: tag 3 again, now free
        step(0, 0, 1, 3, 0, 0, 1);
        // R2: refill picks the lowest free tag while a completion arrives
        step(1, 77, 1, 0, 2, 0, 0);
        // R8: several expiries drain one per cycle
        idle((SHORT + 2) * DIV + DEPTH);

        // Mixed traffic
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom % 100);
            step(($urandom % 3) == 0, int'($urandom % 256), r < 45,
                 int'($urandom % DEPTH),
                 (r % 10 == 0) ? 1 : ((r % 10 == 1) ? 2 : 0),
                 ($urandom % 10) == 0, ($urandom % 10) < 6);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule